// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block is the combinational decode and execute stage of a small 32-bit load-store integer core. It receives one 32-bit instruction word and the two source operand values already read from the register file. It returns the two source register indices for the register file, an ALU result, a destination register index and a write enable. For word loads and stores it also returns the effective memory address and a read or write request.

The instruction layout is fixed. The opcode always sits in the top six bits. Register-format instructions carry opcode 0 and select their operation through a 6-bit function code in the low bits. Immediate-format instructions carry a 16-bit constant in the low half, and each opcode selects either sign extension, zero extension or placement in the upper half. Register 0 is the constant zero and is never written, so the stage drops the write enable whenever the destination index is 0. An unknown opcode or function code raises an illegal flag and blocks every side effect.

The stage has no clock and holds no state. It sits between the operand read and the write-back registers of the surrounding pipeline.

Top module: `rx_exec_unit`

## Requirements
- R1: Field positions: opcode is instr[31:26], first source index is instr[25:21] (driven on src_a_idx), second source index is instr[20:16] (driven on src_b_idx), register-format destination is instr[15:11], shift amount is instr[10:6], function code is instr[5:0], and the immediate is instr[15:0].
- R2: With opcode 0x00, the function codes 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x27 nor, 0x00 shift-left-logical and 0x02 shift-right-logical are accepted. Their destination is instr[15:11].
- R3: Add and subtract (both register and immediate forms) wrap modulo 2^32 without any overflow indication.
- R4: NOR returns ~(rs_val | rt_val). With a zero operand it therefore gives the bitwise inverse of the other operand.
- R5: The shifts move rt_val by instr[10:6] places (0 to 31) and fill the vacated bits with zeros. rs_val has no effect on them.
- R6: Add-immediate (0x08) and set-less-than-immediate (0x0A) sign-extend the 16-bit constant. Set-less-than-immediate returns 1 when rs_val is less than the constant as signed values and 0 otherwise. Immediate-format destinations are instr[20:16].
- R7: And-immediate (0x0C) and or-immediate (0x0D) zero-extend the constant.
- R8: Load-upper-immediate (0x0F) returns the constant in bits 31:16 and zeros in bits 15:0. rs_val has no effect on it.
- R9: Word load (0x23) drives mem_addr = rs_val + sign-extended constant, raises mem_rd, returns the same address on result and targets instr[20:16] with the write enable.
- R10: Word store (0x2B) drives the same address form, raises mem_wr and keeps wr_en low.
- R11: wr_en is never high while wr_idx is 0.
- R12: An unrecognised opcode, or opcode 0x00 with an unrecognised function code, raises illegal and drives wr_en, mem_rd and mem_wr low and result to 0.
- R13: Outside word loads and stores, mem_rd and mem_wr are low and mem_addr is 0. mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| src_a_idx | output | 5 | First source register index for the register file |
| src_b_idx | output | 5 | Second source register index for the register file |
| result | output | 32 | Execute result |
| wr_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| mem_addr | output | 32 | Effective word address, 0 when no memory access |
| mem_rd | output | 1 | Word load request |
| mem_wr | output | 1 | Word store request |
| illegal | output | 1 | Unrecognised opcode or function code |

## Verification
The checker watches properties that must hold for any instruction word. The write enable never pairs with destination 0. An illegal instruction has no side effects. The two memory requests never overlap, and the address is zero when no access is requested. A store never writes a register. A load returns its address on result. Load-upper-immediate clears the low half, and set-less-than returns a single bit. The arithmetic values themselves are covered only by the bench's scenarios: wrap-around of add and subtract, signed versus unsigned comparison, the choice between sign and zero extension, shift boundaries at 0 and 31 places, the NOT idiom through NOR, the upper-then-lower constant build, and negative address offsets.

// File: rtl/rx_exec_pkg.sv
package rx_exec_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;
    localparam int REG_IDX_W = 5;
    localparam int SHAMT_W   = 5;
    localparam int IMM_W     = 16;

    // opcodes (instr[31:26])
    localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_LDW  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STW  = 6'h2B;

    // function codes (instr[5:0]) under OPC_REG
    localparam logic [FUNCT_W-1:0] FN_SLL = 6'h00;
    localparam logic [FUNCT_W-1:0] FN_SRL = 6'h02;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLL,
        ALU_SRL,
        ALU_SLT,
        ALU_PASS_B,
        ALU_ZERO
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN,
        IMM_ZERO,
        IMM_HIGH
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   op;
        logic      use_imm;
        imm_kind_e imm_kind;
        logic      dst_is_rt;
        logic      writes;
        logic      mem_rd;
        logic      mem_wr;
        logic      illegal;
    } ctrl_t;

endpackage

// File: rtl/rx_decode.sv
module rx_decode
    import rx_exec_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    input  logic [FUNCT_W-1:0] funct,
    output ctrl_t              ctrl
);

    always_comb begin
        ctrl          = '0;
        ctrl.op       = ALU_ZERO;
        ctrl.imm_kind = IMM_SIGN;
        unique case (opc)
            OPC_REG: begin
                ctrl.writes = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.op = ALU_ADD;
                    FN_SUB:  ctrl.op = ALU_SUB;
                    FN_AND:  ctrl.op = ALU_AND;
                    FN_OR:   ctrl.op = ALU_OR;
                    FN_NOR:  ctrl.op = ALU_NOR;
                    FN_SLL:  ctrl.op = ALU_SLL;
                    FN_SRL:  ctrl.op = ALU_SRL;
                    default: begin
                        ctrl.writes  = 1'b0;
                        ctrl.illegal = 1'b1;
                    end
                endcase
            end
            OPC_ADDI: begin
                ctrl.op        = ALU_ADD;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
            end
            OPC_SLTI: begin
                ctrl.op        = ALU_SLT;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
            end
            OPC_ANDI: begin
                ctrl.op        = ALU_AND;
                ctrl.use_imm   = 1'b1;
                ctrl.imm_kind  = IMM_ZERO;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
            end
            OPC_ORI: begin
                ctrl.op        = ALU_OR;
                ctrl.use_imm   = 1'b1;
                ctrl.imm_kind  = IMM_ZERO;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
            end
            OPC_LUI: begin
                ctrl.op        = ALU_PASS_B;
                ctrl.use_imm   = 1'b1;
                ctrl.imm_kind  = IMM_HIGH;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
            end
            OPC_LDW: begin
                ctrl.op        = ALU_ADD;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.writes    = 1'b1;
                ctrl.mem_rd    = 1'b1;
            end
            OPC_STW: begin
                ctrl.op        = ALU_ADD;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.mem_wr    = 1'b1;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/rx_immgen.sv
module rx_immgen
    import rx_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  imm_kind_e         kind,
    output logic [DATA_W-1:0] value
);

    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        unique case (kind)
            IMM_SIGN: value = {{PAD_W{imm[IMM_W-1]}}, imm};
            IMM_ZERO: value = {{PAD_W{1'b0}}, imm};
            IMM_HIGH: value = {imm, {PAD_W{1'b0}}};
            default:  value = '0;
        endcase
    end

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              to_left,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] flipped_in;
    logic [DATA_W-1:0] flipped_out;
    logic [DATA_W-1:0] stage [AMT_W+1];

    // a right shift is a left shift of the bit-reversed word
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign flipped_in[i]  = din[DATA_W-1-i];
        assign flipped_out[i] = stage[AMT_W][DATA_W-1-i];
    end

    assign stage[0] = to_left ? din : flipped_in;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign dout = to_left ? stage[AMT_W] : flipped_out;

endmodule

// File: rtl/rx_alu.sv
module rx_alu
    import rx_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] y
);

    logic [DATA_W-1:0] shifted;

    rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .din     (b),
        .amt     (amt),
        .to_left (op == ALU_SLL),
        .dout    (shifted)
    );

    always_comb begin
        unique case (op)
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_NOR:    y = ~(a | b);
            ALU_SLL,
            ALU_SRL:    y = shifted;
            ALU_SLT:    y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end

endmodule

// File: rtl/rx_agu.sv
module rx_agu
    import rx_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] base,
    input  logic [IMM_W-1:0]  offset,
    output logic [DATA_W-1:0] addr
);

    logic [DATA_W-1:0] offset_ext;

    assign offset_ext = {{(DATA_W-IMM_W){offset[IMM_W-1]}}, offset};
    assign addr       = en ? (base + offset_ext) : '0;

endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
    import rx_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    rs_val,
    input  logic [DATA_W-1:0]    rt_val,
    output logic [REG_IDX_W-1:0] src_a_idx,
    output logic [REG_IDX_W-1:0] src_b_idx,
    output logic [DATA_W-1:0]    result,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic                 wr_en,
    output logic [DATA_W-1:0]    mem_addr,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 illegal
);

    logic [OPC_W-1:0]     f_opc;
    logic [REG_IDX_W-1:0] f_rd;
    logic [SHAMT_W-1:0]   f_shamt;
    logic [FUNCT_W-1:0]   f_funct;
    logic [IMM_W-1:0]     f_imm;

    // R1: fixed field positions
    assign f_opc     = instr[31:26];
    assign src_a_idx = instr[25:21];
    assign src_b_idx = instr[20:16];
    assign f_rd      = instr[15:11];
    assign f_shamt   = instr[10:6];
    assign f_funct   = instr[5:0];
    assign f_imm     = instr[15:0];

    ctrl_t             ctrl;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] opnd_b;

    rx_decode u_dec (
        .opc   (f_opc),
        .funct (f_funct),
        .ctrl  (ctrl)
    );

    rx_immgen #(.DATA_W(DATA_W)) u_imm (
        .imm   (f_imm),
        .kind  (ctrl.imm_kind),
        .value (imm_val)
    );

    assign opnd_b = ctrl.use_imm ? imm_val : rt_val;

    rx_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (ctrl.op),
        .a   (rs_val),
        .b   (opnd_b),
        .amt (f_shamt[AMT_W-1:0]),
        .y   (result)
    );

    rx_agu #(.DATA_W(DATA_W)) u_agu (
        .en     (ctrl.mem_rd | ctrl.mem_wr),
        .base   (rs_val),
        .offset (f_imm),
        .addr   (mem_addr)
    );

    // R11: register 0 is never written
    assign wr_idx  = ctrl.dst_is_rt ? src_b_idx : f_rd;
    assign wr_en   = ctrl.writes && (wr_idx != '0);
    assign mem_rd  = ctrl.mem_rd;
    assign mem_wr  = ctrl.mem_wr;
    assign illegal = ctrl.illegal;

endmodule

// File: rtl/rx_exec_unit_chk.sv
module rx_exec_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic [5:0]        opc,
    input logic [15:0]       imm,
    input logic [4:0]        rt_field,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        wr_idx,
    input logic              wr_en,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              illegal
);

    always_comb begin
        p_no_zero_write_r11: assert (!(wr_en && wr_idx == 5'd0))
            else $error("write enable raised for register 0");
        p_illegal_quiet_r12: assert (!illegal || (!wr_en && !mem_rd && !mem_wr && result == '0))
            else $error("illegal instruction has a side effect");
        p_mem_exclusive_r13: assert (!(mem_rd && mem_wr))
            else $error("load and store requested together");
        p_addr_idle_r13: assert (mem_rd || mem_wr || mem_addr == '0)
            else $error("address driven without memory access");
        p_store_nowrite_r10: assert (!mem_wr || !wr_en)
            else $error("store writes a register");
        p_load_result_r9: assert (!mem_rd || (result == mem_addr && wr_idx == rt_field))
            else $error("load result or destination mismatch");
        p_upper_const_r8: assert (opc != 6'h0F || (result[15:0] == 16'h0 && result[31:16] == imm))
            else $error("upper constant misplaced");
        p_slt_bool_r6: assert (opc != 6'h0A || result[DATA_W-1:1] == '0)
            else $error("set-less-than result wider than one bit");
    end

endmodule

bind rx_exec_unit rx_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .opc      (instr[31:26]),
    .imm      (instr[15:0]),
    .rt_field (instr[20:16]),
    .result   (result),
    .wr_idx   (wr_idx),
    .wr_en    (wr_en),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .illegal  (illegal)
);

// File: tb/rx_exec_unit_tb.sv
module rx_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [4:0]  src_a_idx, src_b_idx, wr_idx;
    logic [31:0] result, mem_addr;
    logic        wr_en, mem_rd, mem_wr, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rx_exec_unit u_dut (
        .instr     (instr),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .result    (result),
        .wr_idx    (wr_idx),
        .wr_en     (wr_en),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .illegal   (illegal)
    );

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] k);
        return {op, rs, rt, k};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        instr  = i;
        rs_val = a;
        rt_val = b;
        @(posedge clk);
        #2;
    endtask

    task automatic t_idle();
        apply(32'h0, 32'h0, 32'h0);
        chk("R11 idle wr_en", {31'b0, wr_en}, 32'd0);
        chk("R12 idle illegal", {31'b0, illegal}, 32'd0);
        chk("R13 idle mem", {30'b0, mem_rd, mem_wr}, 32'd0);
        chk("R13 idle addr", mem_addr, 32'd0);
        chk("R5 idle result", result, 32'd0);
    endtask

    task automatic t_fields();
        apply(enc_r(6'h20, 5'd17, 5'd18, 5'd8, 5'd0), 32'd5, 32'd6);
        chk("R1 src_a_idx", {27'b0, src_a_idx}, 32'd17);
        chk("R1 src_b_idx", {27'b0, src_b_idx}, 32'd18);
        chk("R2 wr_idx rd", {27'b0, wr_idx}, 32'd8);
        chk("R2 wr_en", {31'b0, wr_en}, 32'd1);
        chk("R2 add", result, 32'd11);
    endtask

    task automatic t_arith();
        apply(enc_r(6'h20, 5'd1, 5'd2, 5'd3, 5'd0), 32'hFFFF_FFFF, 32'd2);
        chk("R3 add wrap", result, 32'd1);
        apply(enc_r(6'h22, 5'd1, 5'd2, 5'd3, 5'd0), 32'd3, 32'd5);
        chk("R3 sub wrap", result, 32'hFFFF_FFFE);
        apply(enc_r(6'h22, 5'd1, 5'd2, 5'd3, 5'd0), 32'h8000_0000, 32'd1);
        chk("R3 sub overflow", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_logic();
        logic [31:0] x = 32'h0000_3C00;
        logic [31:0] y = 32'h0000_0DC0;
        apply(enc_r(6'h24, 5'd9, 5'd10, 5'd8, 5'd0), x, y);
        chk("R2 and", result, x & y);
        apply(enc_r(6'h25, 5'd9, 5'd10, 5'd8, 5'd0), x, y);
        chk("R2 or", result, x | y);
        apply(enc_r(6'h27, 5'd9, 5'd10, 5'd8, 5'd0), x, y);
        chk("R4 nor", result, ~(x | y));
        apply(enc_r(6'h27, 5'd9, 5'd0, 5'd8, 5'd0), x, 32'h0);
        chk("R4 nor as not", result, 32'hFFFF_C3FF);
    endtask

    task automatic t_shifts();
        apply(enc_r(6'h00, 5'd7, 5'd16, 5'd10, 5'd8), 32'hDEAD_BEEF, 32'h1234_5678);
        chk("R5 sll 8", result, 32'h3456_7800);
        apply(enc_r(6'h02, 5'd7, 5'd16, 5'd10, 5'd8), 32'hDEAD_BEEF, 32'h8765_4321);
        chk("R5 srl 8 zero fill", result, 32'h0087_6543);
        apply(enc_r(6'h00, 5'd7, 5'd16, 5'd10, 5'd31), 32'h0, 32'h0000_0003);
        chk("R5 sll 31", result, 32'h8000_0000);
        apply(enc_r(6'h02, 5'd7, 5'd16, 5'd10, 5'd31), 32'h0, 32'hC000_0000);
        chk("R5 srl 31", result, 32'h0000_0001);
        apply(enc_r(6'h02, 5'd7, 5'd16, 5'd10, 5'd0), 32'hFFFF_FFFF, 32'hA5A5_0F0F);
        chk("R5 srl 0 rs ignored", result, 32'hA5A5_0F0F);
    endtask

    task automatic t_imm_arith();
        apply(enc_i(6'h08, 5'd17, 5'd18, 16'hFFFF), 32'd10, 32'hFFFF_FFFF);
        chk("R6 addi -1", result, 32'd9);
        chk("R6 addi dest rt", {27'b0, wr_idx}, 32'd18);
        apply(enc_i(6'h08, 5'd17, 5'd18, 16'h7FFF), 32'd1, 32'h0);
        chk("R6 addi max", result, 32'h0000_8000);
        apply(enc_i(6'h0A, 5'd18, 5'd8, 16'h000F), 32'd14, 32'h0);
        chk("R6 slti less", result, 32'd1);
        apply(enc_i(6'h0A, 5'd18, 5'd8, 16'h000F), 32'd15, 32'h0);
        chk("R6 slti equal", result, 32'd0);
        apply(enc_i(6'h0A, 5'd18, 5'd8, 16'h0001), 32'hFFFF_FFFE, 32'h0);
        chk("R6 slti signed neg", result, 32'd1);
        apply(enc_i(6'h0A, 5'd18, 5'd8, 16'hFFFE), 32'd0, 32'h0);
        chk("R6 slti neg imm", result, 32'd0);
    endtask

    task automatic t_imm_logic();
        apply(enc_i(6'h0C, 5'd9, 5'd8, 16'hFF00), 32'hFFFF_FFFF, 32'h0);
        chk("R7 andi zext", result, 32'h0000_FF00);
        apply(enc_i(6'h0D, 5'd9, 5'd8, 16'h8000), 32'h0000_0001, 32'h0);
        chk("R7 ori zext", result, 32'h0000_8001);
    endtask

    task automatic t_upper();
        logic [31:0] hi;
        apply(enc_i(6'h0F, 5'd31, 5'd8, 16'hAAAA), 32'h1234_5678, 32'h0);
        chk("R8 lui", result, 32'hAAAA_0000);
        hi = result;
        apply(enc_i(6'h0D, 5'd8, 5'd8, 16'h5555), hi, 32'h0);
        chk("R8 lui then ori", result, 32'hAAAA_5555);
    endtask

    task automatic t_mem();
        apply(enc_i(6'h23, 5'd19, 5'd8, 16'd24), 32'h1200_4094, 32'h0);
        chk("R9 load addr", mem_addr, 32'h1200_40AC);
        chk("R9 load req", {30'b0, mem_rd, mem_wr}, 32'd2);
        chk("R9 load result", result, 32'h1200_40AC);
        chk("R9 load dest", {26'b0, wr_en, wr_idx}, {26'b0, 1'b1, 5'd8});
        apply(enc_i(6'h2B, 5'd19, 5'd8, 16'hFFF8), 32'h0000_0100, 32'hCAFE_0000);
        chk("R10 store addr neg", mem_addr, 32'h0000_00F8);
        chk("R10 store req", {30'b0, mem_rd, mem_wr}, 32'd1);
        chk("R10 store wr_en", {31'b0, wr_en}, 32'd0);
        apply(enc_i(6'h08, 5'd19, 5'd8, 16'd24), 32'h1200_4094, 32'h0);
        chk("R13 addr idle on addi", mem_addr, 32'd0);
        chk("R13 no req on addi", {30'b0, mem_rd, mem_wr}, 32'd0);
    endtask

    task automatic t_zero_dest();
        apply(enc_r(6'h20, 5'd1, 5'd2, 5'd0, 5'd0), 32'd1, 32'd2);
        chk("R11 rd zero", {31'b0, wr_en}, 32'd0);
        apply(enc_i(6'h08, 5'd1, 5'd0, 16'd5), 32'd1, 32'd0);
        chk("R11 rt zero", {31'b0, wr_en}, 32'd0);
        apply(enc_i(6'h23, 5'd1, 5'd0, 16'd4), 32'd8, 32'd0);
        chk("R11 load to zero", {31'b0, wr_en}, 32'd0);
    endtask

    task automatic t_illegal();
        apply(enc_i(6'h3F, 5'd1, 5'd2, 16'h1234), 32'd7, 32'd9);
        chk("R12 bad opcode flag", {31'b0, illegal}, 32'd1);
        chk("R12 bad opcode quiet", {29'b0, wr_en, mem_rd, mem_wr}, 32'd0);
        chk("R12 bad opcode result", result, 32'd0);
        apply(enc_r(6'h21, 5'd1, 5'd2, 5'd3, 5'd0), 32'd7, 32'd9);
        chk("R12 bad funct flag", {31'b0, illegal}, 32'd1);
        chk("R12 bad funct wr_en", {31'b0, wr_en}, 32'd0);
        chk("R12 bad funct result", result, 32'd0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_fields();
        t_arith();
        t_logic();
        t_shifts();
        t_imm_arith();
        t_imm_logic();
        t_upper();
        t_mem();
        t_zero_dest();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule